// File: doc/BRIEF.md
# Beam-Synchronized Display Coprocessor

This block is a small instruction-driven controller that steps through a list of two-word instructions held in memory and acts on them in time with the raster beam. Three instruction kinds exist. A register-write instruction drives a one-cycle write strobe with an 8-bit register index and 16 bits of data. A stall instruction holds execution until the beam reaches a masked vertical/horizontal position. A conditional-skip instruction passes over the next instruction when that position has already been reached. Other logic in the chip can be started by writing its registers, and an interrupt can be raised the same way.

The list has no terminating instruction. Each start-of-frame pulse reloads the fetch pointer from the list base input and runs the list from its first word. A list is closed with a stall on a position the beam never reaches. While the controller is parked there it makes no memory reads. Register indices below a protected limit are only written while the unlock input is high.

The controller has three states. FETCH reads the two words, using internal sub-phases ISSUE0, ISSUE1 and LATCH1. EXEC acts on the instruction. HOLD waits for the beam. The transitions are:
- FETCH goes to EXEC after LATCH1.
- EXEC goes to FETCH after a register write or a skip test.
- EXEC goes to HOLD for a stall instruction.
- HOLD goes to FETCH once the position is reached.
- A start-of-frame pulse forces FETCH/ISSUE0 from any state.
- Reset enters HOLD with no list armed.

Top module: `bsync_copro`

## Requirements
- R1: After reset the controller is parked. `mem_rd` and `reg_we` stay low until the first `frame_start` pulse, whatever the beam position.
- R2: A `frame_start` sampled high at a clock edge restarts the list from any state. In the next cycle `mem_rd` is high and `mem_addr` equals `list_base`.
- R3: An instruction fetch makes two read cycles back to back, at word addresses `a` and `a+1`. `mem_rdata` must carry the addressed word in the cycle after its read, and the next instruction is fetched from `a+2`.
- R4: A first word with bit 0 = 0 is a register write. Its bits [8:1] are the register index driven on `reg_addr`, and the whole second word is driven on `reg_wdata`.
- R5: A register write raises `reg_we` for exactly one cycle, three cycles after the first read of its fetch. No read is made in that cycle.
- R6: A register write whose index is below `PROT_LIMIT` (default 0x20) produces no strobe while `danger_en` is low. Execution then continues with the next instruction.
- R7: A first word with bit 0 = 1 and a second word with bit 0 = 0 is a stall. The fields are: first word [15:8] vertical position, first word [7:1] horizontal position, second word [15:8] vertical mask, second word [7:1] horizontal mask. The instruction is released when {beam_v & vmask, beam_h & hmask} >= {vpos & vmask, hpos & hmask}, with the vertical part more significant.
- R8: A first word with bit 0 = 1 and a second word with bit 0 = 1 is a conditional skip, using the same comparison as R7. If the comparison holds, the following instruction is not executed. If it does not hold, execution continues with the following instruction.
- R9: There is no end instruction. While stalled on a position not reached, the controller makes no memory reads and no register writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle start-of-frame pulse that restarts the list |
| list_base | input | AW | Word address of the first instruction |
| beam_v | input | VW | Current vertical beam position |
| beam_h | input | HW | Current horizontal beam position |
| danger_en | input | 1 | Allows writes to indices below PROT_LIMIT |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | AW | Word address of the read |
| mem_rdata | input | 1+HW+VW | Read data, valid the cycle after `mem_rd` |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_addr | output | RAW | Register index of the write |
| reg_wdata | output | 1+HW+VW | Register write data |

## Verification
The bound checker checks the following on every cycle:
- the write strobe lasts one cycle and never coincides with a read;
- no protected index is strobed while the unlock input is low;
- each restart lands on the list base;
- a fetch's second read follows its first at the next address.

Some behaviours depend on memory contents and beam values, so only the bench's scenarios can show them:
- the decoded index and data of each write;
- the order of the writes;
- whether a masked stall holds or releases on the vertical and horizontal comparison;
- whether a skip drops exactly one instruction;
- the absence of any read while the list is parked.

// File: rtl/copro_pkg.sv
package copro_pkg;

    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_EXEC  = 2'd1,
        ST_HOLD  = 2'd2
    } cp_state_e;

    typedef enum logic [1:0] {
        PH_ISSUE0 = 2'd0,
        PH_ISSUE1 = 2'd1,
        PH_LATCH1 = 2'd2
    } cp_phase_e;

    typedef enum logic [1:0] {
        K_MOVE = 2'd0,
        K_WAIT = 2'd1,
        K_SKIP = 2'd2
    } cp_kind_e;

    typedef enum logic [1:0] {
        PC_HOLD = 2'd0,
        PC_INC1 = 2'd1,
        PC_INC2 = 2'd2
    } cp_pcop_e;

endpackage

// File: rtl/copro_decode.sv
module copro_decode
    import copro_pkg::*;
#(
    parameter int VW  = 8,
    parameter int HW  = 7,
    parameter int RAW = 8,
    localparam int WW = 1 + HW + VW
) (
    input  logic [WW-1:0]  word0,
    input  logic [WW-1:0]  word1,
    output cp_kind_e       kind,
    output logic [RAW-1:0] reg_idx,
    output logic [VW-1:0]  vpos,
    output logic [HW-1:0]  hpos,
    output logic [VW-1:0]  vmask,
    output logic [HW-1:0]  hmask
);
    // Bit 0 of the first word separates writes from beam tests.
    // Bit 0 of the second word then separates stall from skip.
    always_comb begin
        if (!word0[0])
            kind = K_MOVE;
        else if (!word1[0])
            kind = K_WAIT;
        else
            kind = K_SKIP;
    end

    assign reg_idx = word0[1 +: RAW];
    assign hpos    = word0[1 +: HW];
    assign vpos    = word0[1 + HW +: VW];
    assign hmask   = word1[1 +: HW];
    assign vmask   = word1[1 + HW +: VW];

endmodule

// File: rtl/copro_beam_cmp.sv
module copro_beam_cmp #(
    parameter int VW = 8,
    parameter int HW = 7
) (
    input  logic [VW-1:0] beam_v,
    input  logic [HW-1:0] beam_h,
    input  logic [VW-1:0] vpos,
    input  logic [HW-1:0] hpos,
    input  logic [VW-1:0] vmask,
    input  logic [HW-1:0] hmask,
    output logic          reached
);
    localparam int CW = VW + HW;

    logic [CW-1:0] beam_key;
    logic [CW-1:0] goal_key;

    // Vertical position is the more significant half of the key.
    assign beam_key = {beam_v & vmask, beam_h & hmask};
    assign goal_key = {vpos & vmask, hpos & hmask};
    assign reached  = (beam_key >= goal_key);

endmodule

// File: rtl/copro_pc.sv
module copro_pc
    import copro_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  cp_pcop_e      op,
    output logic [AW-1:0] pc
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
        end else if (load) begin
            pc <= base;
        end else begin
            unique case (op)
                PC_HOLD: pc <= pc;
                PC_INC1: pc <= pc + AW'(1);
                PC_INC2: pc <= pc + AW'(2);
                default: pc <= pc;
            endcase
        end
    end

endmodule

// File: rtl/bsync_copro.sv
module bsync_copro
    import copro_pkg::*;
#(
    parameter int AW         = 16,
    parameter int VW         = 8,
    parameter int HW         = 7,
    parameter int RAW        = 8,
    parameter int PROT_LIMIT = 32,
    localparam int WW        = 1 + HW + VW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           frame_start,
    input  logic [AW-1:0]  list_base,
    input  logic [VW-1:0]  beam_v,
    input  logic [HW-1:0]  beam_h,
    input  logic           danger_en,
    output logic           mem_rd,
    output logic [AW-1:0]  mem_addr,
    input  logic [WW-1:0]  mem_rdata,
    output logic           reg_we,
    output logic [RAW-1:0] reg_addr,
    output logic [WW-1:0]  reg_wdata
);
    cp_state_e      state, state_nxt;
    cp_phase_e      phase, phase_nxt;
    cp_pcop_e       pc_op;
    cp_kind_e       kind;
    logic           armed;
    logic           ld_w0, ld_w1;
    logic [WW-1:0]  ins_w0, ins_w1;
    logic [AW-1:0]  pc;
    logic [RAW-1:0] reg_idx;
    logic [VW-1:0]  vpos, vmask;
    logic [HW-1:0]  hpos, hmask;
    logic           reached;
    logic           move_ok;

    copro_pc #(.AW(AW)) u_pc (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (frame_start),
        .base  (list_base),
        .op    (pc_op),
        .pc    (pc)
    );

    copro_decode #(.VW(VW), .HW(HW), .RAW(RAW)) u_dec (
        .word0   (ins_w0),
        .word1   (ins_w1),
        .kind    (kind),
        .reg_idx (reg_idx),
        .vpos    (vpos),
        .hpos    (hpos),
        .vmask   (vmask),
        .hmask   (hmask)
    );

    copro_beam_cmp #(.VW(VW), .HW(HW)) u_cmp (
        .beam_v  (beam_v),
        .beam_h  (beam_h),
        .vpos    (vpos),
        .hpos    (hpos),
        .vmask   (vmask),
        .hmask   (hmask),
        .reached (reached)
    );

    assign move_ok = danger_en || (reg_idx >= RAW'(PROT_LIMIT));

    // State register: the frame pulse overrides every transition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_HOLD;
            phase  <= PH_ISSUE0;
            armed  <= 1'b0;
            ins_w0 <= '0;
            ins_w1 <= '0;
        end else begin
            if (frame_start) begin
                state <= ST_FETCH;
                phase <= PH_ISSUE0;
                armed <= 1'b1;
            end else begin
                state <= state_nxt;
                phase <= phase_nxt;
            end
            if (ld_w0) ins_w0 <= mem_rdata;
            if (ld_w1) ins_w1 <= mem_rdata;
        end
    end

    // Next state and outputs.
    always_comb begin
        state_nxt = state;
        phase_nxt = phase;
        pc_op     = PC_HOLD;
        mem_rd    = 1'b0;
        ld_w0     = 1'b0;
        ld_w1     = 1'b0;
        reg_we    = 1'b0;
        unique case (state)
            ST_FETCH: begin
                unique case (phase)
                    PH_ISSUE0: begin
                        mem_rd    = 1'b1;
                        pc_op     = PC_INC1;
                        phase_nxt = PH_ISSUE1;
                    end
                    PH_ISSUE1: begin
                        mem_rd    = 1'b1;
                        ld_w0     = 1'b1;
                        pc_op     = PC_INC1;
                        phase_nxt = PH_LATCH1;
                    end
                    default: begin
                        ld_w1     = 1'b1;
                        phase_nxt = PH_ISSUE0;
                        state_nxt = ST_EXEC;
                    end
                endcase
            end
            ST_EXEC: begin
                unique case (kind)
                    K_MOVE: begin
                        reg_we    = move_ok;
                        state_nxt = ST_FETCH;
                    end
                    K_WAIT: begin
                        state_nxt = ST_HOLD;
                    end
                    default: begin
                        if (reached) pc_op = PC_INC2;
                        state_nxt = ST_FETCH;
                    end
                endcase
            end
            ST_HOLD: begin
                if (armed && reached) state_nxt = ST_FETCH;
            end
            default: state_nxt = ST_HOLD;
        endcase
    end

    assign mem_addr  = pc;
    assign reg_addr  = reg_idx;
    assign reg_wdata = ins_w1;

endmodule

// File: rtl/bsync_copro_chk.sv
module bsync_copro_chk #(
    parameter int AW         = 16,
    parameter int RAW        = 8,
    parameter int PROT_LIMIT = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           frame_start,
    input logic [AW-1:0]  list_base,
    input logic           danger_en,
    input logic           mem_rd,
    input logic [AW-1:0]  mem_addr,
    input logic           reg_we,
    input logic [RAW-1:0] reg_addr
);
    // R5: strobe lasts a single cycle
    assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R5: no read alongside a write strobe
    assert_strobe_no_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> !mem_rd);

    // R6: protected indices stay silent while locked
    assert_protected_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !danger_en) |-> (reg_addr >= RAW'(PROT_LIMIT)));

    // R2: restart reads from the list base
    assert_restart_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (mem_rd && mem_addr == $past(list_base)));

    // R3: second word read at the next address
    assert_fetch_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_rd) && !frame_start) |=> (mem_rd && mem_addr == AW'($past(mem_addr) + 1'b1)));

endmodule

bind bsync_copro bsync_copro_chk #(
    .AW(AW), .RAW(RAW), .PROT_LIMIT(PROT_LIMIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .list_base   (list_base),
    .danger_en   (danger_en),
    .mem_rd      (mem_rd),
    .mem_addr    (mem_addr),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr)
);

// File: tb/bsync_copro_tb.sv
module bsync_copro_tb;
    localparam int AW = 16;
    localparam int VW = 8;
    localparam int HW = 7;
    localparam int RAW = 8;
    localparam int WW = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           frame_start = 1'b0;
    logic [AW-1:0]  list_base = '0;
    logic [VW-1:0]  beam_v = '0;
    logic [HW-1:0]  beam_h = '0;
    logic           danger_en = 1'b0;
    logic           mem_rd;
    logic [AW-1:0]  mem_addr;
    logic [WW-1:0]  mem_rdata = '0;
    logic           reg_we;
    logic [RAW-1:0] reg_addr;
    logic [WW-1:0]  reg_wdata;

    logic [WW-1:0]  mem [0:63];
    logic [RAW-1:0] log_addr [0:63];
    logic [WW-1:0]  log_data [0:63];
    int             wr_cnt = 0;
    int             rd_cnt = 0;
    int             n_chk = 0;
    int             n_bad = 0;
    bit             done = 1'b0;

    always #2 clk = ~clk;

    bsync_copro u_dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .list_base(list_base), .beam_v(beam_v), .beam_h(beam_h),
        .danger_en(danger_en), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata)
    );

    always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[5:0]];

    always @(negedge clk) begin
        if (rst_n && reg_we && wr_cnt < 64) begin
            log_addr[wr_cnt] = reg_addr;
            log_data[wr_cnt] = reg_wdata;
            wr_cnt = wr_cnt + 1;
        end
        if (rst_n && mem_rd) rd_cnt = rd_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic put_move(input int idx, input logic [7:0] ra, input logic [15:0] d);
        mem[idx]     = {7'b0, ra, 1'b0};
        mem[idx + 1] = d;
    endtask

    task automatic put_cmp(input int idx, input logic [7:0] vp, input logic [6:0] hp,
                           input logic [7:0] vm, input logic [6:0] hm, input bit skip);
        mem[idx]     = {vp, hp, 1'b1};
        mem[idx + 1] = {vm, hm, skip};
    endtask

    task automatic put_end(input int idx);
        put_cmp(idx, 8'hFF, 7'h7F, 8'hFF, 7'h7F, 1'b0);
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int base);
        @(negedge clk);
        list_base   = AW'(base);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic t_reset;
        cyc(10);
        chk(reg_we == 1'b0, "R1 reg_we after reset", int'(reg_we), 0);
        chk(mem_rd == 1'b0, "R1 mem_rd after reset", int'(mem_rd), 0);
        chk(rd_cnt == 0, "R1 no reads before frame", rd_cnt, 0);
    endtask

    task automatic t_move_timing;
        int b;
        put_move(0, 8'h40, 16'hCAFE);
        put_move(2, 8'h41, 16'hBEEF);
        put_end(4);
        b = wr_cnt;
        pulse(0);
        chk(mem_rd && mem_addr == 16'd0, "R2 first read at base", int'(mem_addr), 0);
        cyc(1);
        chk(mem_rd && mem_addr == 16'd1, "R3 second word read", int'(mem_addr), 1);
        cyc(1);
        chk(!reg_we && !mem_rd, "R5 no strobe during latch", int'(reg_we), 0);
        cyc(1);
        chk(reg_we && !mem_rd, "R5 strobe three cycles after read", int'(reg_we), 1);
        chk(reg_addr == 8'h40 && reg_wdata == 16'hCAFE, "R4 index and data",
            int'({reg_addr, reg_wdata}), 32'h40CAFE);
        cyc(1);
        chk(!reg_we && mem_rd && mem_addr == 16'd2, "R5 strobe one cycle, R3 next at a+2",
            int'(mem_addr), 2);
        cyc(20);
        chk(wr_cnt - b == 2, "R4 write count", wr_cnt - b, 2);
        chk(log_addr[b + 1] == 8'h41 && log_data[b + 1] == 16'hBEEF, "R4 second write",
            int'({log_addr[b + 1], log_data[b + 1]}), 32'h41BEEF);
    endtask

    task automatic t_park;
        int r, w;
        r = rd_cnt;
        w = wr_cnt;
        cyc(40);
        chk(rd_cnt == r, "R9 no reads while parked", rd_cnt - r, 0);
        chk(wr_cnt == w, "R9 no writes while parked", wr_cnt - w, 0);
    endtask

    task automatic t_protect;
        int b;
        put_move(8, 8'h05, 16'h1234);
        put_move(10, 8'h30, 16'h5678);
        put_end(12);
        danger_en = 1'b0;
        b = wr_cnt;
        pulse(8);
        cyc(30);
        chk(wr_cnt - b == 1, "R6 locked write dropped", wr_cnt - b, 1);
        chk(log_addr[b] == 8'h30, "R6 unprotected write kept", int'(log_addr[b]), 8'h30);
        danger_en = 1'b1;
        b = wr_cnt;
        pulse(8);
        cyc(30);
        chk(wr_cnt - b == 2 && log_addr[b] == 8'h05 && log_data[b] == 16'h1234,
            "R6 unlocked write", int'(log_addr[b]), 8'h05);
        danger_en = 1'b0;
    endtask

    task automatic t_wait_restart;
        int b;
        put_move(16, 8'h42, 16'h1111);
        put_cmp(18, 8'd10, 7'd0, 8'hFF, 7'h7F, 1'b0);
        put_move(20, 8'h43, 16'h2222);
        put_end(22);
        beam_v = 8'd5;
        beam_h = 7'd0;
        b = wr_cnt;
        pulse(16);
        cyc(30);
        chk(wr_cnt - b == 1, "R7 stall before position", wr_cnt - b, 1);
        pulse(16);
        cyc(30);
        chk(wr_cnt - b == 2 && log_addr[b + 1] == 8'h42, "R2 restart mid-stall",
            int'(log_addr[b + 1]), 8'h42);
        beam_v = 8'd10;
        cyc(20);
        chk(wr_cnt - b == 3 && log_addr[b + 2] == 8'h43 && log_data[b + 2] == 16'h2222,
            "R7 released at position", wr_cnt - b, 3);
    endtask

    task automatic t_mask;
        int b;
        put_cmp(24, 8'h03, 7'd0, 8'h0F, 7'h00, 1'b0);
        put_move(26, 8'h44, 16'h3333);
        put_end(28);
        beam_v = 8'h21;
        beam_h = 7'd0;
        b = wr_cnt;
        pulse(24);
        cyc(30);
        chk(wr_cnt == b, "R7 masked vertical below", wr_cnt - b, 0);
        beam_v = 8'h13;
        cyc(20);
        chk(wr_cnt - b == 1 && log_addr[b] == 8'h44, "R7 masked vertical reached",
            wr_cnt - b, 1);
    endtask

    task automatic t_hcmp;
        int b;
        put_cmp(32, 8'h20, 7'h40, 8'hFF, 7'h7F, 1'b0);
        put_move(34, 8'h45, 16'h4444);
        put_end(36);
        beam_v = 8'h20;
        beam_h = 7'h3F;
        b = wr_cnt;
        pulse(32);
        cyc(30);
        chk(wr_cnt == b, "R7 horizontal below", wr_cnt - b, 0);
        beam_h = 7'h40;
        cyc(20);
        chk(wr_cnt - b == 1 && log_addr[b] == 8'h45, "R7 horizontal reached", wr_cnt - b, 1);
        beam_v = 8'h1F;
        beam_h = 7'h7F;
        b = wr_cnt;
        pulse(32);
        cyc(30);
        chk(wr_cnt == b, "R7 vertical dominates horizontal", wr_cnt - b, 0);
    endtask

    task automatic t_skip;
        int b;
        put_cmp(40, 8'h08, 7'd0, 8'hFF, 7'h7F, 1'b1);
        put_move(42, 8'h50, 16'hAAAA);
        put_move(44, 8'h51, 16'hBBBB);
        put_end(46);
        beam_h = 7'd0;
        beam_v = 8'h10;
        b = wr_cnt;
        pulse(40);
        cyc(40);
        chk(wr_cnt - b == 1 && log_addr[b] == 8'h51, "R8 skip taken", wr_cnt - b, 1);
        beam_v = 8'h02;
        b = wr_cnt;
        pulse(40);
        cyc(40);
        chk(wr_cnt - b == 2 && log_addr[b] == 8'h50 && log_addr[b + 1] == 8'h51,
            "R8 skip not taken", wr_cnt - b, 2);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        cyc(3);
        rst_n = 1'b1;
        t_reset();
        t_move_timing();
        t_park();
        t_protect();
        t_wait_restart();
        t_mask();
        t_hcmp();
        t_skip();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule